// File: doc/BRIEF.md
# Memory-Mapped SPI Byte Engine

This block lets a host processor talk to a memory card over SPI through three small registers. The data register sends a byte and returns the byte that came back. The control register holds the card select, the clock rate and the trigger mode. The status register reports whether the engine is busy and shows the card-detect and write-protect pins. Each transfer moves one byte in both directions at the same time, most significant bit first, in SPI mode 0.

Two serial clock rates come from the system clock through one half-period counter: a slow rate near 250 kHz for card start-up and a fast rate near 8 MHz. The engine has two trigger modes. In write-trigger mode, writing a byte to the data register starts the exchange. In read-trigger mode, reading the data register returns the last received byte and also starts a new exchange that sends 0xFF, so a host can stream bytes in from the card with reads alone. The card select is active low. It is driven by software, and the same level drives the activity LED.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset the control register reads 0x02, the data register reads 0x00, status bit 0 reads 0, spi_cs_n and led_n are 1, and spi_sck is 0.
- R2: In write-trigger mode (control bit 6 = 0), a write to address 0 while idle sends the written byte MSB first in SPI mode 0. spi_mosi is stable while spi_sck is high, and the card samples it on the rising edge.
- R3: When a transfer ends, the 8 bits sampled from spi_miso on the rising edges (first bit is the MSB) can be read at address 0. A read during a transfer returns the previous byte.
- R4: Control bit 2 sets the spi_sck half period: 0 gives max(1, CLK_HZ/(2*SLOW_HZ)) clock cycles and 1 gives max(1, CLK_HZ/(2*FAST_HZ)) cycles. The rate is captured when the transfer starts.
- R5: Control bit 1 drives spi_cs_n (0 = card selected), and led_n always has the same value as spi_cs_n.
- R6: In read-trigger mode (control bit 6 = 1), a read of address 0 while idle returns the previously received byte and starts an exchange that sends 0xFF. A write to address 0 in this mode starts nothing.
- R7: Status bit 0 reads 1 from the cycle after the start access until the exchange completes. A transfer is 16 half periods long, and spi_sck toggles only while busy.
- R8: Status bit 3 mirrors card_det_n (0 = card present), and status bit 4 mirrors card_wp (0 = writable). Status bits 1, 2, 5, 6 and 7 read 0.
- R9: Control bits 0, 3, 4, 5 and 7 read 0 whatever value was written.
- R10: An access to address 0 that would start a transfer while busy is ignored. The byte in flight and its length are not changed, and no second transfer follows.
- R11: spi_sck rests low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Card select, active low |
| led_n | output | 1 | Activity LED, active low |
| card_det_n | input | 1 | 0 = card inserted |
| card_wp | input | 1 | 1 = card write-protected |

## Verification
The bench builds the engine with CLK_HZ = 16,000,000 and keeps the default rates. This gives a slow half period of 32 cycles and a fast half period of 1 cycle. The slow rate therefore has a measurable pulse width of 32 cycles and a 512-cycle transfer that leaves room for accesses while busy. The fast rate reaches the divider's lower clamp, where each edge follows on the next clock.

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int SLOW_HZ = 250_000,
  parameter int FAST_HZ = 8_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       led_n,
  input  logic       card_det_n,
  input  logic       card_wp
);

  localparam int SLOW_RAW  = CLK_HZ / (2 * SLOW_HZ);
  localparam int FAST_RAW  = CLK_HZ / (2 * FAST_HZ);
  localparam int SLOW_HALF = (SLOW_RAW < 1) ? 1 : SLOW_RAW;
  localparam int FAST_HALF = (FAST_RAW < 1) ? 1 : FAST_RAW;
  localparam int MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW        = $clog2(MAX_HALF + 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);

  logic          cs_q, fast_q, rdtrig_q;
  logic          busy, fast_run, sck_q;
  logic [CW-1:0] cnt;
  logic [3:0]    edges;
  logic [7:0]    tx, rx, data_q;

  wire data_rd = bus_sel && !bus_we && bus_addr == 2'd0;
  wire data_wr = bus_sel &&  bus_we && bus_addr == 2'd0;
  wire ctrl_wr = bus_sel &&  bus_we && bus_addr == 2'd1;
  wire start   = !busy && (rdtrig_q ? data_rd : data_wr);
  wire tick    = busy && cnt == (fast_run ? FAST_LIM : SLOW_LIM);

  assign spi_sck  = sck_q;
  assign spi_mosi = tx[7];
  assign spi_cs_n = cs_q;
  assign led_n    = cs_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = data_q;
      2'd1:    bus_rdata = {1'b0, rdtrig_q, 3'b000, fast_q, cs_q, 1'b0};
      2'd2:    bus_rdata = {3'b000, card_wp, card_det_n, 2'b00, busy};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      fast_q   <= 1'b0;
      rdtrig_q <= 1'b0;
    end else if (ctrl_wr) begin
      cs_q     <= bus_wdata[1];
      fast_q   <= bus_wdata[2];
      rdtrig_q <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fast_run <= 1'b0;
      sck_q    <= 1'b0;
      cnt      <= '0;
      edges    <= '0;
      tx       <= 8'h00;
      rx       <= 8'h00;
      data_q   <= 8'h00;
    end else if (start) begin
      busy     <= 1'b1;
      fast_run <= fast_q;
      cnt      <= '0;
      edges    <= '0;
      tx       <= rdtrig_q ? 8'hFF : bus_wdata;
    end else if (tick) begin
      cnt   <= '0;
      edges <= edges + 4'd1;
      if (!edges[0]) begin
        sck_q <= 1'b1;
        rx    <= {rx[6:0], spi_miso};
      end else begin
        sck_q <= 1'b0;
        tx    <= {tx[6:0], 1'b0};
        if (edges == 4'd15) begin
          busy   <= 1'b0;
          data_q <= rx;
        end
      end
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck); // R11
  AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $past(busy)); // R7
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R2
  AST_CS_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (spi_cs_n == $past(bus_wdata[1])) && (led_n == spi_cs_n)); // R5
  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd2) |-> (bus_rdata[7:5] == 3'b000 && bus_rdata[2:1] == 2'b00)); // R8
  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd1) |-> (bus_rdata[0] == 1'b0 && bus_rdata[5:3] == 3'b000 && bus_rdata[7] == 1'b0)); // R9

endmodule

// File: tb/spi_byte_engine_tb_top.sv
`timescale 1ns/1ps
module spi_byte_engine_tb_top;

  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       spi_sck, spi_mosi, spi_cs_n, led_n;
  logic       card_det_n = 0, card_wp = 0;
  logic [7:0] sl_tx = 8'h00, sl_rx = 8'h00;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  spi_byte_engine #(.CLK_HZ(16_000_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(sl_tx[7]),
    .spi_cs_n(spi_cs_n), .led_n(led_n), .card_det_n(card_det_n), .card_wp(card_wp));

  always @(posedge spi_sck) sl_rx <= {sl_rx[6:0], spi_mosi};
  always @(negedge spi_sck) sl_tx <= {sl_tx[6:0], 1'b0};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic high_width(output int w);
    w = 0;
    while (!spi_sck) @(negedge clk);
    while (spi_sck) begin w++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 led_n", led_n, 1);
    chk("R1 sck", spi_sck, 0);
    rd(2'd1, v); chk("R1 control", v, 8'h02);
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    rd(2'd2, v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_status_pins();
    logic [7:0] v;
    card_det_n = 1; card_wp = 1;
    rd(2'd2, v); chk("R8 status no card, protected", v, 8'h18);
    card_det_n = 0; card_wp = 1;
    rd(2'd2, v); chk("R8 status protected", v, 8'h10);
    card_det_n = 1; card_wp = 0;
    rd(2'd2, v); chk("R8 status no card", v, 8'h08);
    card_det_n = 0;
  endtask

  task automatic t_control();
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R9 control spare bits", v, 8'h46);
    chk("R5 cs_n deselect", spi_cs_n, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R9 control cleared", v, 8'h00);
    chk("R5 cs_n select", spi_cs_n, 0);
    chk("R5 led follows", led_n, 0);
  endtask

  task automatic t_fast_write();
    logic [7:0] v;
    int w;
    wr(2'd1, 8'h04);
    sl_tx = 8'h3C;
    wr(2'd0, 8'hA5);
    rd(2'd2, v); chk("R7 busy after start", v[0], 1);
    high_width(w); chk("R4 fast half period", w, 1);
    wait_idle();
    chk("R2 byte sent", sl_rx, 8'hA5);
    chk("R11 sck idle", spi_sck, 0);
    rd(2'd0, v); chk("R3 byte received", v, 8'h3C);
  endtask

  task automatic t_slow_busy();
    logic [7:0] v;
    int w;
    wr(2'd1, 8'h00);
    sl_tx = 8'hC3;
    wr(2'd0, 8'h5A);
    high_width(w); chk("R4 slow half period", w, 32);
    rd(2'd0, v); chk("R3 old byte during busy", v, 8'h3C);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk("R7 still busy", v[0], 1);
    wait_idle();
    chk("R10 in-flight byte unchanged", sl_rx, 8'h5A);
    rd(2'd0, v); chk("R3 slow byte received", v, 8'hC3);
    w = 0;
    repeat (100) begin @(negedge clk); if (spi_sck) w++; end
    chk("R10 no second transfer", w, 0);
  endtask

  task automatic t_read_trigger();
    logic [7:0] v;
    wr(2'd1, 8'h44);
    wr(2'd0, 8'h12);
    rd(2'd2, v); chk("R6 write ignored in read mode", v[0], 0);
    chk("R6 nothing sent by write", sl_rx, 8'h5A);
    sl_tx = 8'h81;
    rd(2'd0, v); chk("R6 read returns previous", v, 8'hC3);
    wait_idle();
    chk("R6 sends 0xFF", sl_rx, 8'hFF);
    sl_tx = 8'h00;
    rd(2'd0, v); chk("R6 next read returns new byte", v, 8'h81);
    wait_idle();
    rd(2'd1, v);
    rd(2'd0, v); chk("R6 chained read byte", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status_pins();
    t_control();
    t_fast_write();
    t_slow_busy();
    t_read_trigger();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual expired expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule